// File: doc/BRIEF.md
# Page Hamming ECC Checker

This block sits beside the data bus of a NAND flash interface and snoops every data transfer. It builds a single-error-correcting Hamming code over the whole data area of one page. Each data bit is given a 16-bit position: its word index within the page in the upper twelve bits and its bit offset within the word in the lower four. A parity word collects the XOR of the positions of all set bits. An inverted-parity word collects the XOR of their complements.

When a page is programmed, software reads the two 16-bit words after the data has passed and stores them in the spare area. When a page is read, the four stored check bytes must come over the bus straight after the last data word. The block then compares them with what it computed and reports one of four outcomes: a clean page, a single data-bit error with its location, a single flipped bit inside the check bytes, or an uncorrectable error. A freshly erased page of all ones shows a fixed signature that software accepts as clean.

Software drives the block through a small register file. It has a control register whose bit 0 clears the accumulators. This drops address cycles that the bus snoop would otherwise count. Software also uses a mode register, a status register and the two parity registers.

Top module: `page_ecc_top`

## Requirements
- R1: The register at address 1 holds the mode and reads back the value written. Bits 1:0 select the data area as 512, 1024, 2048 or 4096 bytes for codes 0 to 3, which gives full pages of 528, 1056, 2112 and 4224 bytes. Bit 2 set selects a 16-bit bus; clear selects an 8-bit bus. Address 0 is the write-only control register, address 2 is status, address 3 is parity and address 4 is inverted parity.
- R2: Each accepted data transfer (bus_valid high) at word index i contributes every set data bit j at position {i[11:0], j[3:0]}. The parity register (address 3) holds the XOR of these positions and the inverted-parity register (address 4) holds the XOR of their complements. On an 8-bit bus, bus_data[15:8] is ignored.
- R3: Only the first data-area words after a clear are accumulated. Later transfers, such as spare-area writes, leave both parity registers unchanged.
- R4: Writing 1 to bit 0 of the control register zeroes both parity accumulators and the transfer count. This discards transfers seen before it.
- R5: On a read page (bus_write low), the four transfers after the data area are taken on bus_data[7:0] as stored parity low byte, parity high byte, inverted-parity low byte and inverted-parity high byte.
- R6: Status and location are updated by the second clock edge after the last check byte is taken. For a clean page, status reads 0 and the parity register reads 0.
- R7: For a single data-bit error, status reads 3'b001 (bit 0 = error found). The parity register reads the location, with the bit offset in bits 3:0 and the word index in bits 15:4.
- R8: For a single flipped bit in the stored check bytes, status reads 3'b011 (bit 1 = error lies in check bytes).
- R9: Any other non-zero difference gives status 3'b101 (bit 2 = multiple errors).
- R10: An erased page, with all data and check bytes at 0xFF, reports status 3'b101 with location 16'hFFFF.
- R11: Status and location hold until the first data transfer after a clear, which zeroes the status. A control clear alone leaves them unchanged. Reset zeroes everything.
- R12: With a 16-bit bus, the word index counts 16-bit words and the bit offset ranges over 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A data transfer takes place this cycle |
| bus_write | input | 1 | 1 = transfer to flash, 0 = transfer from flash |
| bus_data | input | 16 | Data word on the flash bus |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |

## Verification
A wrong transfer count or a wrong phase boundary moves every later position. The first page checked would then report a multiple error or a wrong location instead of a clean result, within two cycles of the last check byte. A corrupted accumulator shows up straight away in the parity registers after a programmed page. A bad byte slot in the stored check value shows up as a check-byte or multiple error on a clean page. Status that fails to hold or fails to clear is visible at the status register on the very next read after a clear or after the first new data word.

// File: rtl/page_ecc_pkg.sv
// Package: shared widths, status codes and the page-size decode.
// Assumes the location field is {word index, bit offset} and fits 16 bits.
package page_ecc_pkg;
    localparam int BIT_W = 4;
    localparam int IDX_W = 12;
    localparam int POS_W = IDX_W + BIT_W;
    localparam int CHK_BYTES = 4;

    typedef logic [2:0] ecc_status_t;
    localparam ecc_status_t ST_NONE  = 3'b000;
    localparam ecc_status_t ST_DATA  = 3'b001;
    localparam ecc_status_t ST_CHK   = 3'b011;
    localparam ecc_status_t ST_MULTI = 3'b101;
endpackage

// File: rtl/page_ecc_acc.sv
// Parity accumulator: folds the positions of all set bits of each data word
// into a running XOR, plus the parity of the set-bit count.
// Assumes word_idx is the word index within the page and clr has priority.
module page_ecc_acc
    import page_ecc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             data_en,
    input  logic             wide,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [BUS_W-1:0] data,
    output logic [POS_W-1:0] acc_p,
    output logic             acc_par
);
    localparam int NARROW_W = BUS_W / 2;

    logic [POS_W-1:0] word_x;
    logic             word_par;

    // Combine the positions of the set bits in the current word.
    always_comb begin
        word_x   = '0;
        word_par = 1'b0;
        for (int j = 0; j < BUS_W; j++) begin
            if (data[j] && (wide || j < NARROW_W)) begin
                word_x   = word_x ^ {word_idx, BIT_W'(j)};
                word_par = ~word_par;
            end
        end
    end

    // Running accumulator, cleared by reset or a control clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_p   <= '0;
            acc_par <= 1'b0;
        end else if (data_en) begin
            acc_p   <= acc_p ^ word_x;
            acc_par <= acc_par ^ word_par;
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_p == '0) && !acc_par); // R4
endmodule

// File: rtl/page_ecc_seq.sv
// Transfer sequencer: counts transfers since a clear, splits them into the
// data phase and the four-byte check phase, and flags the end of a read page.
// Assumes `words` stays constant while a page is in flight.
module page_ecc_seq
    import page_ecc_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [CNT_W-1:0] words,
    output logic             data_en,
    output logic [IDX_W-1:0] word_idx,
    output logic             chk_en,
    output logic [1:0]       chk_sel,
    output logic             first_word,
    output logic             finish
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] chk_off;
    logic             in_data;
    logic             in_chk;

    // Phase decode from the transfer count.
    always_comb begin
        limit      = words + CNT_W'(CHK_BYTES);
        chk_off    = cnt - words;
        in_data    = cnt < words;
        in_chk     = !in_data && (cnt < limit);
        data_en    = bus_valid && in_data;
        chk_en     = bus_valid && in_chk && !bus_write;
        chk_sel    = chk_off[1:0];
        word_idx   = cnt[IDX_W-1:0];
        first_word = bus_valid && (cnt == '0);
    end

    // Transfer counter, saturating once the check phase is over.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (bus_valid && cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe one cycle after the last check byte has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            finish <= 1'b0;
        end else begin
            finish <= chk_en && (chk_sel == 2'd3);
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit); // R3
    AST_FINISH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> $past(bus_valid && !bus_write)); // R5
endmodule

// File: rtl/page_ecc_classify.sv
// Syndrome classifier: compares computed and stored codes and names the
// outcome. Purely combinational; assumes the stored bytes are complete.
module page_ecc_classify
    import page_ecc_pkg::*;
(
    input  logic [POS_W-1:0]       calc_p,
    input  logic [POS_W-1:0]       calc_n,
    input  logic [2*POS_W-1:0]     stored,
    output ecc_status_t            status,
    output logic [POS_W-1:0]       loc
);
    logic [POS_W-1:0] syn_p;
    logic [POS_W-1:0] syn_n;

    // Decide the error class from the two syndrome halves.
    always_comb begin
        syn_p = calc_p ^ stored[POS_W-1:0];
        syn_n = calc_n ^ stored[2*POS_W-1:POS_W];
        loc   = syn_p;
        if ({syn_p, syn_n} == '0) begin
            status = ST_NONE;
        end else if ((syn_p ^ syn_n) == '1) begin
            status = ST_DATA;
        end else if ($countones({syn_p, syn_n}) == 1) begin
            status = ST_CHK;
        end else begin
            status = ST_MULTI;
        end
    end
endmodule

// File: rtl/page_ecc_top.sv
// Page Hamming ECC checker top: register file, check-byte capture and the
// result registers. Assumes one transfer per cycle at most and that software
// clears the accumulators before each page's data phase.
module page_ecc_top
    import page_ecc_pkg::*;
#(
    parameter int BUS_W          = 16,
    parameter int MIN_DATA_BYTES = 512,
    parameter int ADDR_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    localparam int MAX_WORDS = MIN_DATA_BYTES << 3;
    localparam int CNT_W     = $clog2(MAX_WORDS + CHK_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_NPAR = ADDR_W'(4);

    logic [2:0]             mode_q;
    logic                   clr;
    logic [CNT_W-1:0]       data_bytes;
    logic [CNT_W-1:0]       words;
    logic                   data_en, chk_en, first_word, finish;
    logic [IDX_W-1:0]       word_idx;
    logic [1:0]             chk_sel;
    logic [POS_W-1:0]       acc_p, calc_n;
    logic                   acc_par;
    logic [8*CHK_BYTES-1:0] chk_q;
    ecc_status_t            cls_status, status_q;
    logic [POS_W-1:0]       cls_loc, loc_q;
    logic                   res_valid;

    // Control decode and data-area size from the mode register.
    always_comb begin
        clr        = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
        data_bytes = CNT_W'(MIN_DATA_BYTES) << mode_q[1:0];
        words      = mode_q[2] ? (data_bytes >> 1) : data_bytes;
        calc_n     = acc_p ^ {POS_W{acc_par}};
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (reg_wr && reg_addr == A_MODE) begin
            mode_q <= reg_wdata[2:0];
        end
    end

    page_ecc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .bus_valid(bus_valid), .bus_write(bus_write), .words(words),
        .data_en(data_en), .word_idx(word_idx), .chk_en(chk_en),
        .chk_sel(chk_sel), .first_word(first_word), .finish(finish)
    );

    page_ecc_acc #(.BUS_W(BUS_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .data_en(data_en),
        .wide(mode_q[2]), .word_idx(word_idx), .data(bus_data),
        .acc_p(acc_p), .acc_par(acc_par)
    );

    // Capture the stored check bytes into their slots.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            chk_q <= '0;
        end else if (chk_en) begin
            chk_q[chk_sel*8 +: 8] <= bus_data[7:0];
        end
    end

    page_ecc_classify u_cls (
        .calc_p(acc_p), .calc_n(calc_n), .stored(chk_q),
        .status(cls_status), .loc(cls_loc)
    );

    // Result registers: cleared on a new page, loaded when a read page ends.
    always_ff @(posedge clk) begin
        if (!rst_n || first_word) begin
            status_q  <= ST_NONE;
            loc_q     <= '0;
            res_valid <= 1'b0;
        end else if (finish) begin
            status_q  <= cls_status;
            loc_q     <= cls_loc;
            res_valid <= 1'b1;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = {13'd0, mode_q};
            A_STAT:  reg_rdata = {13'd0, status_q};
            A_PAR:   reg_rdata = res_valid ? loc_q : acc_p;
            A_NPAR:  reg_rdata = calc_n;
            default: reg_rdata = '0;
        endcase
    end

    AST_ERR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[1] || status_q[2]) |-> status_q[0]); // R8
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_q[1] && status_q[2])); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_word && !finish) |=> $stable(status_q)); // R11
endmodule

// File: tb/page_ecc_top_bench.sv
module page_ecc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_data = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] pg [0:4095];

    page_ecc_top u_page_ecc_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_data(bus_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference code {inverted, parity} built bit by bit from the page.
    function automatic logic [31:0] ref_code(input int nwords, input bit wide);
        logic [15:0] p = '0;
        logic [15:0] n = '0;
        for (int i = 0; i < nwords; i++) begin
            for (int j = 0; j < (wide ? 16 : 8); j++) begin
                if (pg[i][j]) begin
                    p ^= {i[11:0], j[3:0]};
                    n ^= ~{i[11:0], j[3:0]};
                end
            end
        end
        return {n, p};
    endfunction

    task automatic xfer(input bit wr, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = wr; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fill(input int nwords, input bit wide, input bit ones);
        for (int i = 0; i < nwords; i++)
            pg[i] = ones ? 16'hFFFF : (wide ? 16'($urandom) : {8'h00, 8'($urandom)});
    endtask

    task automatic stream(input bit wr, input int nwords, input bit wide,
                          input bit send_chk, input logic [31:0] chk);
        for (int i = 0; i < nwords; i++)
            xfer(wr, wide ? pg[i] : {8'($urandom), pg[i][7:0]});
        if (send_chk)
            for (int k = 0; k < 4; k++) xfer(1'b0, {8'($urandom), chk[8*k +: 8]});
        repeat (3) @(negedge clk);
    endtask

    task automatic read_page(input int nwords, input bit wide, input logic [31:0] chk,
                             output logic [15:0] st, output logic [15:0] loc);
        reg_write(3'd0, 16'h1);
        stream(1'b0, nwords, wide, 1'b1, chk);
        reg_read(3'd2, st);
        reg_read(3'd3, loc);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] st, loc, v;
        logic [31:0] code;
        int w, b, w2, b2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        reg_read(3'd2, v); check("R11 reset status", v, 0);
        reg_read(3'd3, v); check("R2 reset parity", v, 0);
        reg_read(3'd4, v); check("R2 reset inverted", v, 0);
        reg_read(3'd1, v); check("R1 reset mode", v, 0);

        // Programmed page, 512 bytes on an 8-bit bus
        reg_write(3'd1, 16'h0);
        fill(512, 0, 0); code = ref_code(512, 0);
        reg_write(3'd0, 16'h1);
        stream(1'b1, 512, 0, 1'b0, 0);
        reg_read(3'd3, v); check("R2 write parity", v, code[15:0]);
        reg_read(3'd4, v); check("R2 write inverted", v, code[31:16]);
        for (int k = 0; k < 20; k++) xfer(1'b1, 16'($urandom));
        reg_read(3'd3, v); check("R3 spare writes ignored parity", v, code[15:0]);
        reg_read(3'd4, v); check("R3 spare writes ignored inverted", v, code[31:16]);

        // Clean read
        read_page(512, 0, code, st, loc);
        check("R6 clean status", st, 0);
        check("R5 clean location", loc, 0);

        // Single data error
        w = $urandom % 512; b = $urandom % 8;
        pg[w][b] = ~pg[w][b];
        read_page(512, 0, code, st, loc);
        check("R7 single status", st, 3'b001);
        check("R7 single location", loc, {w[11:0], b[3:0]});
        pg[w][b] = ~pg[w][b];

        // Check-byte error
        b = $urandom % 32;
        read_page(512, 0, code ^ (32'd1 << b), st, loc);
        check("R8 check-byte status", st, 3'b011);

        // Double data error
        w = $urandom % 256; w2 = 256 + $urandom % 256; b = $urandom % 8; b2 = $urandom % 8;
        pg[w][b] = ~pg[w][b]; pg[w2][b2] = ~pg[w2][b2];
        read_page(512, 0, code, st, loc);
        check("R9 double status", st, 3'b101);

        // Erased page
        fill(512, 0, 1);
        read_page(512, 0, 32'hFFFF_FFFF, st, loc);
        check("R10 erased status", st, 3'b101);
        check("R10 erased location", loc, 16'hFFFF);

        // Status hold across clear, cleared by first data word
        reg_write(3'd0, 16'h1);
        reg_read(3'd2, v); check("R11 held after clear", v, 3'b101);
        reg_read(3'd3, v); check("R11 location held", v, 16'hFFFF);
        xfer(1'b0, 16'h00FF);
        reg_read(3'd2, v); check("R11 cleared by first word", v, 0);

        // Clear drops address cycles
        fill(512, 0, 0); code = ref_code(512, 0);
        reg_write(3'd0, 16'h1);
        for (int k = 0; k < 3; k++) xfer(1'b1, 16'($urandom));
        reg_write(3'd0, 16'h1);
        stream(1'b1, 512, 0, 1'b0, 0);
        reg_read(3'd3, v); check("R4 parity after clear", v, code[15:0]);
        reg_read(3'd4, v); check("R4 inverted after clear", v, code[31:16]);

        // Random single errors
        for (int t = 0; t < 6; t++) begin
            fill(512, 0, 0); code = ref_code(512, 0);
            w = $urandom % 512; b = $urandom % 8;
            pg[w][b] = ~pg[w][b];
            read_page(512, 0, code, st, loc);
            check("R7 random single status", st, 3'b001);
            check("R7 random single location", loc, {w[11:0], b[3:0]});
        end

        // 16-bit bus, 1024-byte data area
        reg_write(3'd1, 16'h5);
        reg_read(3'd1, v); check("R1 mode readback", v, 16'h5);
        fill(512, 1, 0); code = ref_code(512, 1);
        read_page(512, 1, code, st, loc);
        check("R12 wide clean status", st, 0);
        w = $urandom % 512; b = 8 + $urandom % 8;
        pg[w][b] = ~pg[w][b];
        read_page(512, 1, code, st, loc);
        check("R12 wide single status", st, 3'b001);
        check("R12 wide single location", loc, {w[11:0], b[3:0]});

        // Largest page, error in the last bit of the last word
        reg_write(3'd1, 16'h3);
        fill(4096, 0, 0); code = ref_code(4096, 0);
        pg[4095][7] = ~pg[4095][7];
        read_page(4096, 0, code, st, loc);
        check("R1 largest page status", st, 3'b001);
        check("R7 largest page location", loc, 16'hFFF7);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule